// File: doc/BRIEF.md
# Indexed Command Window Bridge

This bridge lets a host whose address window is only a few words wide reach a controller whose command space needs a 28-bit direct address. The host first stores a control word at the control offset. The bridge keeps that word. When the host later reads or writes the data offset, the bridge issues one request on the wide internal command bus, using the stored word as the address.

The top two bits of the internal address select one of four command classes. The bridge decodes them into a one-hot select that travels with each request. The lower bits carry the bank and the page or block number, and they pass through unchanged.

The stored word stays in place across any number of data accesses, so the host can stream reads or writes to one address after a single control write. A data access holds the host (ready low) until the internal side acknowledges it. A separate output flag reports that indexed addressing is built in.

Host handshake rules:
- The host raises `h_valid` and keeps `h_valid`, `h_write`, `h_addr` and `h_wdata` steady until it sees `h_ready` high at a rising edge.
- `h_rdata` and `h_err` are meaningful only in that cycle.

Internal handshake rules:
- `c_valid` and its payload stay steady until `c_ack` is high at a rising edge.
- For reads, `c_rdata` is sampled in the acknowledging cycle.

Top module: `idxwin_bridge`

## Requirements
- R1: A host write to offset 0x00 stores the low 28 bits of `h_wdata` as the control word. A host read of offset 0x00 returns the stored word with the upper four bits zero. Both complete with `h_ready` high in the first cycle of `h_valid` and `h_err` low.
- R2: After a control write, a host write to offset 0x10 causes exactly one internal write, with `c_write`=1, `c_addr` equal to the control word and `c_wdata` equal to the host data. It completes with `h_err` low.
- R3: After a control write, a host read of offset 0x10 causes exactly one internal read, with `c_write`=0 at the control word address. The host receives the acknowledged `c_rdata` with `h_err` low.
- R4: The control word persists. Successive data accesses without a new control write all use the same internal address. A new control write replaces the address used by later accesses.
- R5: `cmd_sel` is one-hot while `c_valid` is high, with bit k set where k = `c_addr[27:26]`. The codes are 00 buffer access, 01 paged transfer, 10 control command and 11 raw data cycle. `cmd_sel` is zero while `c_valid` is low. `c_addr[25:0]` (bank and page/block) equals the low 26 bits of the control word.
- R6: A forwarded data access holds `h_ready` low until the internal side acknowledges. `c_valid` rises one cycle after `h_valid`. `h_ready` rises in the cycle after `c_valid` and `c_ack` are both high, so an acknowledge latency of L cycles gives completion L+2 cycles after `h_valid` is raised. `c_valid`, `c_addr`, `c_write` and `c_wdata` stay steady until acknowledged.
- R7: A data access (read or write at 0x10) made before any control write since reset makes no internal request. It completes in the first cycle with `h_rdata`=0 and `h_err`=1.
- R8: An access at any other offset completes in the first cycle with `h_rdata`=0 and `h_err`=1. It makes no internal request and leaves the control word unchanged.
- R9: `idx_present` is 1 when the parameter `INDEXED` is 1, its default.
- R10: During and right after reset, `h_ready`, `c_valid` and `cmd_sel` are low, and the control word reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request completes this cycle |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid with h_ready |
| h_err | output | 1 | Access error, valid with h_ready |
| c_valid | output | 1 | Internal request valid |
| c_ack | input | 1 | Internal request acknowledge |
| c_write | output | 1 | Internal request is a write |
| c_addr | output | 28 | Internal command address |
| c_wdata | output | 32 | Internal write data |
| c_rdata | input | 32 | Internal read data, sampled with c_ack |
| cmd_sel | output | 4 | One-hot command class of the current request |
| idx_present | output | 1 | Indexed addressing is implemented |

## Verification
The bench aims at data accesses made before any control word exists. A design that forwarded them would show up as an unexpected internal request or a missing error flag.

It streams several reads after one control write. A bridge that cleared the word after use would miss the second internal request or send it to a wrong address.

It checks the exact completion cycle for acknowledge latencies of zero and several cycles. An off-by-one or a missing stall would show up as a wrong count, and data captured in the wrong cycle would show up as wrong read data.

It tries all four class codes and an unmapped offset. A wrong slice of the class bits would light the wrong select line. An unmapped access that leaked into the control register would change the readback value.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;
  localparam int NUM_CLS = 4;
  localparam int CLS_W   = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_BUF = 2'b00,
    CLS_PIO = 2'b01,
    CLS_CMD = 2'b10,
    CLS_RAW = 2'b11
  } cmd_class_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_DONE = 2'b10
  } xfer_st_e;
endpackage

// File: rtl/idxwin_ctrl_latch.sv
module idxwin_ctrl_latch #(
  parameter int CMD_AW = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMD_AW-1:0] wr_data,
  output logic [CMD_AW-1:0] word,
  output logic              vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
      vld  <= 1'b0;
    end else if (wr_en) begin
      word <= wr_data;
      vld  <= 1'b1;
    end
  end

  // R4
  word_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(word));

  // R7
  vld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> vld);
endmodule

// File: rtl/idxwin_class_decode.sv
module idxwin_class_decode
  import idxwin_pkg::*;
#(
  parameter int CMD_AW = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [CMD_AW-1:0]  addr,
  output logic [NUM_CLS-1:0] sel
);
  localparam int CLS_LSB = CMD_AW - CLS_W;

  cmd_class_e code;
  assign code = cmd_class_e'(addr[CMD_AW-1:CLS_LSB]);

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_sel
    assign sel[i] = en && (code == cmd_class_e'(i));
  end

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R5
  sel_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (sel == '0));
endmodule

// File: rtl/idxwin_xfer_fsm.sv
module idxwin_xfer_fsm
  import idxwin_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CMD_AW = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [DW-1:0]     start_wdata,
  input  logic [CMD_AW-1:0] start_addr,
  output logic              idle,
  output logic              done,
  output logic [DW-1:0]     rdata_q,
  output logic              c_valid,
  input  logic              c_ack,
  output logic              c_write,
  output logic [CMD_AW-1:0] c_addr,
  output logic [DW-1:0]     c_wdata,
  input  logic [DW-1:0]     c_rdata
);
  xfer_st_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      c_write <= 1'b0;
      c_addr  <= '0;
      c_wdata <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st      <= ST_BUSY;
          c_write <= start_we;
          c_addr  <= start_addr;
          c_wdata <= start_wdata;
          rdata_q <= '0;
        end
        ST_BUSY: if (c_ack) begin
          st <= ST_DONE;
          if (!c_write) rdata_q <= c_rdata;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign c_valid = (st == ST_BUSY);
  assign idle    = (st == ST_IDLE);
  assign done    = (st == ST_DONE);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && !c_ack) |=> (c_valid && $stable(c_addr) && $stable(c_write) && $stable(c_wdata)));

  // R6
  ack_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && c_ack) |=> (done && !c_valid));

  // R6
  start_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> c_valid);
endmodule

// File: rtl/idxwin_bridge.sv
module idxwin_bridge
  import idxwin_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          HOST_AW  = 8,
  parameter int          CMD_AW   = 28,
  parameter logic [7:0]  CTRL_OFF = 8'h00,
  parameter logic [7:0]  DATA_OFF = 8'h10,
  parameter bit          INDEXED  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_valid,
  output logic               h_ready,
  input  logic               h_write,
  input  logic [HOST_AW-1:0] h_addr,
  input  logic [DW-1:0]      h_wdata,
  output logic [DW-1:0]      h_rdata,
  output logic               h_err,
  output logic               c_valid,
  input  logic               c_ack,
  output logic               c_write,
  output logic [CMD_AW-1:0]  c_addr,
  output logic [DW-1:0]      c_wdata,
  input  logic [DW-1:0]      c_rdata,
  output logic [NUM_CLS-1:0] cmd_sel,
  output logic               idx_present
);
  localparam int PAD_W = DW - CMD_AW;

  logic              is_ctrl, is_data, is_other;
  logic              idle, done, fwd, ctrl_wr, ctrl_vld;
  logic [CMD_AW-1:0] ctrl_word;
  logic [DW-1:0]     fsm_rdata;

  assign is_ctrl  = (h_addr == HOST_AW'(CTRL_OFF));
  assign is_data  = (h_addr == HOST_AW'(DATA_OFF));
  assign is_other = !is_ctrl && !is_data;

  assign fwd     = h_valid && idle && is_data && ctrl_vld;
  assign ctrl_wr = h_valid && idle && is_ctrl && h_write;

  idxwin_ctrl_latch #(.CMD_AW(CMD_AW)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr),
    .wr_data(h_wdata[CMD_AW-1:0]), .word(ctrl_word), .vld(ctrl_vld)
  );

  idxwin_xfer_fsm #(.DW(DW), .CMD_AW(CMD_AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(fwd), .start_we(h_write),
    .start_wdata(h_wdata), .start_addr(ctrl_word), .idle(idle),
    .done(done), .rdata_q(fsm_rdata), .c_valid(c_valid), .c_ack(c_ack),
    .c_write(c_write), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata)
  );

  idxwin_class_decode #(.CMD_AW(CMD_AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(c_valid), .addr(c_addr), .sel(cmd_sel)
  );

  always_comb begin
    h_ready = 1'b0;
    h_err   = 1'b0;
    h_rdata = '0;
    if (done) begin
      h_ready = 1'b1;
      h_rdata = fsm_rdata;
    end else if (h_valid && idle && !fwd) begin
      h_ready = 1'b1;
      h_err   = is_other || is_data;
      if (is_ctrl && !h_write) h_rdata = {{PAD_W{1'b0}}, ctrl_word};
    end
  end

  assign idx_present = INDEXED;

  // R7
  no_req_without_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> ctrl_vld);

  // R6
  stall_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> !h_ready);

  // R8
  other_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && h_valid && is_other) |=> !c_valid);
endmodule

// File: tb/idxwin_bridge_tb.sv
module idxwin_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_valid = 1'b0, h_write = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready, h_err;
  logic [31:0] h_rdata;
  logic        c_valid, c_write;
  logic        c_ack = 1'b0;
  logic [27:0] c_addr;
  logic [31:0] c_wdata;
  logic [31:0] c_rdata = '0;
  logic [3:0]  cmd_sel;
  logic        idx_present;

  int checks = 0, failures = 0;
  int lat = 0, wcnt = 0;
  int n_acc = 0;
  logic        lg_we;
  logic [27:0] lg_addr;
  logic [31:0] lg_wdata;
  logic [3:0]  lg_sel;

  always #4 clk = ~clk;

  idxwin_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
    .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .h_err(h_err), .c_valid(c_valid), .c_ack(c_ack), .c_write(c_write),
    .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata), .cmd_sel(cmd_sel),
    .idx_present(idx_present)
  );

  function automatic logic [31:0] mem_val(input logic [27:0] a);
    return {4'hC, a} ^ 32'h0000_5A5A;
  endfunction

  always @(negedge clk) begin
    if (c_ack) begin
      c_ack = 1'b0;
    end else if (c_valid) begin
      if (wcnt >= lat) begin
        c_ack    = 1'b1;
        c_rdata  = mem_val(c_addr);
        n_acc    = n_acc + 1;
        lg_we    = c_write;
        lg_addr  = c_addr;
        lg_wdata = c_wdata;
        lg_sel   = cmd_sel;
        wcnt     = 0;
      end else begin
        wcnt = wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic host(input logic we, input logic [7:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output logic er, output int cyc);
    @(negedge clk);
    h_valid = 1'b1; h_write = we; h_addr = a; h_wdata = wd;
    cyc = 0;
    #1;
    while (!h_ready && cyc < 60) begin
      @(negedge clk); #1; cyc++;
    end
    rd = h_rdata; er = h_err;
    @(posedge clk); #1;
    h_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic er; int cyc;
    chk(h_ready == 1'b0, "R10 ready in reset", 32'(h_ready), 0);
    chk(c_valid == 1'b0, "R10 c_valid in reset", 32'(c_valid), 0);
    chk(cmd_sel == 4'b0, "R10 cmd_sel in reset", 32'(cmd_sel), 0);
    chk(idx_present == 1'b1, "R9 idx_present", 32'(idx_present), 1);
    @(negedge clk); rst_n = 1'b1;
    host(1'b0, 8'h00, 0, rd, er, cyc);
    chk(rd == 32'h0, "R10 ctrl word after reset", rd, 0);
  endtask

  task automatic t_no_ctrl();
    logic [31:0] rd; logic er; int cyc; int n0;
    n0 = n_acc;
    host(1'b0, 8'h10, 0, rd, er, cyc);
    chk(rd == 0 && er == 1'b1, "R7 early read data/err", {rd[30:0], er}, 32'h1);
    chk(cyc == 0, "R7 early read immediate", cyc, 0);
    host(1'b1, 8'h10, 32'h1234_5678, rd, er, cyc);
    chk(er == 1'b1, "R7 early write err", 32'(er), 1);
    repeat (3) @(negedge clk);
    chk(n_acc == n0, "R7 no internal access", n_acc, n0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] rd; logic er; int cyc;
    host(1'b1, 8'h00, 32'hFFFF_FFFF, rd, er, cyc);
    chk(cyc == 0 && er == 1'b0, "R1 ctrl write immediate", cyc, 0);
    host(1'b0, 8'h00, 0, rd, er, cyc);
    chk(rd == 32'h0FFF_FFFF, "R1 ctrl readback masked", rd, 32'h0FFF_FFFF);
    chk(er == 1'b0 && cyc == 0, "R1 ctrl read ok", {cyc[30:0], er}, 0);
  endtask

  task automatic t_write();
    logic [31:0] rd; logic er; int cyc; int n0;
    lat = 0;
    host(1'b1, 8'h00, 32'h0600_1234, rd, er, cyc);
    n0 = n_acc;
    host(1'b1, 8'h10, 32'hDEAD_BEEF, rd, er, cyc);
    chk(n_acc == n0 + 1, "R2 one internal write", n_acc, n0 + 1);
    chk(lg_we == 1'b1 && lg_addr == 28'h600_1234, "R2 write address", {3'b0, lg_we, lg_addr}, 32'h1600_1234);
    chk(lg_wdata == 32'hDEAD_BEEF, "R2 write data", lg_wdata, 32'hDEAD_BEEF);
    chk(er == 1'b0, "R2 write no err", 32'(er), 0);
    chk(cyc == 2, "R6 zero latency completion", cyc, 2);
    chk(lg_sel == 4'b0010, "R5 class 01 select", 32'(lg_sel), 32'h2);
    chk(c_valid == 1'b0 && cmd_sel == 4'b0, "R5 select idle zero", 32'(cmd_sel), 0);
  endtask

  task automatic t_read_lat();
    logic [31:0] rd; logic er; int cyc; int n0;
    lat = 3;
    host(1'b1, 8'h00, 32'h0ABC_DEF0, rd, er, cyc);
    n0 = n_acc;
    host(1'b0, 8'h10, 0, rd, er, cyc);
    chk(rd == mem_val(28'hABC_DEF0), "R3 read data", rd, mem_val(28'hABC_DEF0));
    chk(lg_we == 1'b0 && lg_addr == 28'hABC_DEF0, "R3 read address", 32'(lg_addr), 32'h0ABC_DEF0);
    chk(er == 1'b0 && n_acc == n0 + 1, "R3 single read no err", n_acc, n0 + 1);
    chk(cyc == 5, "R6 stall with latency 3", cyc, 5);
    lat = 0;
  endtask

  task automatic t_stream();
    logic [31:0] rd; logic er; int cyc; int n0;
    lat = 1;
    host(1'b1, 8'h00, 32'h0000_0F0F, rd, er, cyc);
    n0 = n_acc;
    for (int k = 0; k < 3; k++) begin
      host(1'b0, 8'h10, 0, rd, er, cyc);
      chk(rd == mem_val(28'h0000F0F) && lg_addr == 28'h0000F0F, "R4 streamed read", rd, mem_val(28'h0000F0F));
    end
    chk(n_acc == n0 + 3, "R4 three accesses", n_acc, n0 + 3);
    host(1'b1, 8'h00, 32'h0000_0111, rd, er, cyc);
    host(1'b0, 8'h10, 0, rd, er, cyc);
    chk(lg_addr == 28'h0000111, "R4 new control word used", 32'(lg_addr), 32'h111);
    lat = 0;
  endtask

  task automatic t_classes();
    logic [31:0] rd; logic er; int cyc;
    for (int k = 0; k < 4; k++) begin
      logic [27:0] a;
      a = {k[1:0], 26'h2A5_5A5A};
      host(1'b1, 8'h00, {4'h0, a}, rd, er, cyc);
      host(1'b1, 8'h10, 32'(k), rd, er, cyc);
      chk(lg_sel == (4'b1 << k), "R5 class select", 32'(lg_sel), 32'(4'b1 << k));
      chk(lg_addr[25:0] == 26'h2A5_5A5A, "R5 bank/page bits", 32'(lg_addr[25:0]), 32'h2A5_5A5A);
    end
  endtask

  task automatic t_other();
    logic [31:0] rd; logic er; int cyc; int n0;
    host(1'b1, 8'h00, 32'h0123_4567, rd, er, cyc);
    n0 = n_acc;
    host(1'b1, 8'h04, 32'h0FFF_0000, rd, er, cyc);
    chk(er == 1'b1 && cyc == 0, "R8 other write err", 32'(er), 1);
    host(1'b0, 8'h20, 0, rd, er, cyc);
    chk(rd == 0 && er == 1'b1, "R8 other read", rd, 0);
    host(1'b0, 8'h00, 0, rd, er, cyc);
    chk(rd == 32'h0123_4567, "R8 control word unchanged", rd, 32'h0123_4567);
    chk(n_acc == n0, "R8 no internal access", n_acc, n0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_no_ctrl();
    t_ctrl_rw();
    t_write();
    t_read_lat();
    t_stream();
    t_classes();
    t_other();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    $display("FAIL R6 watchdog act=hang exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end
endmodule